// File: doc/BRIEF.md
# Five-Stage Right Shifter with Ones-Only Asynchronous Preset

This block is a chain of five single-bit storage stages that shifts one place toward the highest-numbered stage on every rising clock edge. Stage 0 takes a serial data bit on each edge. The last stage drives a serial output, and every stage is also visible on a parallel output bus. The block can therefore serve as a serial-to-parallel converter or as a short serial delay line.

Each stage can also be forced high at any time, without waiting for the clock. A stage is forced high when a shared preset enable is high and that stage's own preset bit is high. Parallel entry can only write ones. A zero on a preset bit leaves its stage alone. An active-low master clear empties the register asynchronously, but only on stages whose preset is not active. Where both act on a stage, the preset wins.

A stage held by its preset or by the clear ignores clock edges. Every other stage keeps shifting normally.

Top module: `ones_preset_shifter`

## Requirements
- R1: While `clr_n` is low and `preset_en` is low, all five bits of `stage_q` and `ser_out` read 0.
- R2: On a rising `clk` edge, a stage that is neither preset nor cleared takes the previous value of its lower neighbour. Stage 0 takes `ser_in`. Bit index 0 of `stage_q` is the first stage.
- R3: `ser_out` always equals `stage_q[4]`.
- R4: When `preset_en` is high, every stage whose `preset_d` bit is high reads 1 at once, without any clock edge.
- R5: When `preset_en` is high, a stage whose `preset_d` bit is low is not loaded with a zero. It keeps shifting as an unheld stage.
- R6: While `preset_en` is low, `preset_d` has no effect on any stage.
- R7: While `clr_n` is low, every stage whose preset is not active reads 0 at once, without any clock edge.
- R8: When preset and clear act on the same stage together, that stage reads 1.
- R9: A stage held by preset or by clear keeps its forced value across rising clock edges, whatever `ser_in` does.
- R10: Suppose one of preset and clear is released while the other stays active. From the next rising edge, the released stages shift from their held values, and the stages still held keep their forced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; acts on its rising edge |
| ser_in | input | 1 | Serial data into stage 0 |
| preset_en | input | 1 | Shared enable for the per-stage asynchronous presets, active high |
| preset_d | input | 5 | Per-stage preset bits; a 1 forces its stage high while enabled |
| clr_n | input | 1 | Asynchronous master clear, active low; overridden by an active preset |
| stage_q | output | 5 | Parallel view of all stages, bit 0 = first stage |
| ser_out | output | 1 | Serial output, the last stage |

## Verification
The assertions assume that preset and clear are never released in the same instant, because the stage value after that release is not defined. The stimulus always lifts one of them at least a cycle before the other. The assertions also assume that any forced condition is held across at least one rising edge and across the falling edge before it, so the clocked checks see a steady picture. For that reason every asynchronous change in the stimulus is made early in a clock cycle and held for whole cycles.

// File: rtl/onesload_pkg.sv
package onesload_pkg;

  // Default register length.
  localparam int unsigned DEF_STAGES = 5;

  // What currently governs one storage stage.
  typedef enum logic [1:0] {
    CELL_SHIFT = 2'd0,
    CELL_SET   = 2'd1,
    CELL_CLEAR = 2'd2
  } cell_mode_e;

endpackage

// File: rtl/preset_gate.sv
module preset_gate #(
  parameter int unsigned STAGES = onesload_pkg::DEF_STAGES
) (
  input  logic              preset_en,
  input  logic [STAGES-1:0] preset_d,
  input  logic              clr_n,
  output logic [STAGES-1:0] set_v,
  output logic [STAGES-1:0] clr_n_v
);

  // A stage is set only when the shared enable and its own bit agree.
  // The clear is masked wherever a set is active, so the set dominates.
  for (genvar i = 0; i < STAGES; i++) begin : g_gate
    assign set_v[i]   = preset_en & preset_d[i];
    assign clr_n_v[i] = clr_n | set_v[i];
  end

endmodule

// File: rtl/shift_cell.sv
module shift_cell
  import onesload_pkg::*;
(
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_n_i,
  input  logic d_i,
  output logic q_o
);

  cell_mode_e mode;

  always_comb begin
    if (set_i)        mode = CELL_SET;
    else if (!clr_n_i) mode = CELL_CLEAR;
    else              mode = CELL_SHIFT;
  end

  // The asynchronous set outranks the asynchronous clear.
  always_ff @(posedge clk_i or posedge set_i or negedge clr_n_i) begin
    if (set_i)         q_o <= 1'b1;
    else if (!clr_n_i) q_o <= 1'b0;
    else               q_o <= d_i;
  end

  AST_SET_FORCES_ONE: assert property (@(negedge clk_i)
    (mode == CELL_SET) |-> q_o);  // R4

  AST_CLEAR_FORCES_ZERO: assert property (@(negedge clk_i)
    (mode == CELL_CLEAR) |-> !q_o);  // R7

  AST_CELL_TAKES_NEIGHBOUR: assert property (@(posedge clk_i)
    disable iff (mode != CELL_SHIFT)
    1'b1 |=> (q_o == $past(d_i)));  // R2

endmodule

// File: rtl/ones_preset_shifter.sv
module ones_preset_shifter #(
  parameter int unsigned STAGES = onesload_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              ser_in,
  input  logic              preset_en,
  input  logic [STAGES-1:0] preset_d,
  input  logic              clr_n,
  output logic [STAGES-1:0] stage_q,
  output logic              ser_out
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] set_v;
  logic [STAGES-1:0] clr_n_v;
  logic [STAGES-1:0] chain_d;

  initial begin
    if (STAGES < 2) $error("ones_preset_shifter needs at least two stages");
  end

  preset_gate #(.STAGES(STAGES)) u_gate (
    .preset_en (preset_en),
    .preset_d  (preset_d),
    .clr_n     (clr_n),
    .set_v     (set_v),
    .clr_n_v   (clr_n_v)
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign chain_d[i] = ser_in;
    end else begin : g_body
      assign chain_d[i] = stage_q[i-1];
    end

    shift_cell u_cell (
      .clk_i   (clk),
      .set_i   (set_v[i]),
      .clr_n_i (clr_n_v[i]),
      .d_i     (chain_d[i]),
      .q_o     (stage_q[i])
    );
  end

  assign ser_out = stage_q[LAST];

  AST_VECTOR_SHIFT: assert property (@(posedge clk)
    disable iff (!clr_n || preset_en)
    1'b1 |=> (stage_q == {$past(stage_q[LAST-1:0]), $past(ser_in)}));  // R2

  AST_CLEAR_EMPTIES: assert property (@(negedge clk)
    disable iff (preset_en)
    !clr_n |-> (stage_q == '0));  // R7

  AST_PRESET_OVER_CLEAR: assert property (@(negedge clk)
    disable iff (clr_n)
    preset_en |-> (stage_q == preset_d));  // R8

endmodule

// File: tb/sim_ones_preset_shifter.sv
`timescale 1ns/1ps
module sim_ones_preset_shifter;

  localparam int N  = 5;
  localparam int NV = 18;

  // Vector layout: {ser_in, preset_en, preset_d[4:0], clr_n, expected stage_q[4:0]}
  localparam logic [12:0] VEC [0:NV-1] = '{
    13'b1_0_00000_1_00001,
    13'b0_0_00000_1_00010,
    13'b1_0_00000_1_00101,
    13'b1_0_00000_1_01011,
    13'b0_0_00000_1_10110,
    13'b0_1_00101_1_01111,
    13'b0_0_11111_1_11110,
    13'b1_1_10000_0_10000,
    13'b1_1_10000_1_10001,
    13'b0_0_00000_1_00010,
    13'b1_0_01010_0_00000,
    13'b1_1_01010_0_01010,
    13'b1_1_01010_1_11111,
    13'b0_1_00000_1_11110,
    13'b1_0_00000_1_11101,
    13'b0_0_00000_1_11010,
    13'b0_0_00000_1_10100,
    13'b1_0_00000_1_01001
  };

  localparam string TAG [0:NV-1] = '{
    "R2", "R2", "R2", "R2", "R2", "R4", "R6", "R8", "R10",
    "R2", "R7", "R8", "R10", "R5", "R2", "R2", "R2", "R2"
  };

  logic         clk = 1'b0;
  logic         ser_in = 1'b0;
  logic         preset_en = 1'b0;
  logic [N-1:0] preset_d = '0;
  logic         clr_n = 1'b0;
  logic [N-1:0] stage_q;
  logic         ser_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ones_preset_shifter #(.STAGES(N)) u0 (
    .clk       (clk),
    .ser_in    (ser_in),
    .preset_en (preset_en),
    .preset_d  (preset_d),
    .clr_n     (clr_n),
    .stage_q   (stage_q),
    .ser_out   (ser_out)
  );

  task automatic chk(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset: clear held low, preset disabled, junk on preset bits (R1, R6).
    preset_d = 5'b10101;
    repeat (2) @(posedge clk);
    #3;
    chk("R1", "reset stage_q", stage_q, 5'b00000);
    chk("R1", "reset ser_out", {4'b0, ser_out}, 5'b00000);
    @(posedge clk);
    #1;

    // Table walk: apply a vector, let one rising edge pass, then compare.
    for (int v = 0; v < NV; v++) begin
      ser_in    = VEC[v][12];
      preset_en = VEC[v][11];
      preset_d  = VEC[v][10:6];
      clr_n     = VEC[v][5];
      @(posedge clk);
      #1;
      chk(TAG[v], $sformatf("vector %0d stage_q", v), stage_q, VEC[v][4:0]);
      chk("R3", $sformatf("vector %0d ser_out", v), {4'b0, ser_out}, {4'b0, VEC[v][4]});
    end

    // Directed: preset acts without a clock edge (state is 01001 here).
    preset_d  = 5'b00110;
    preset_en = 1'b1;
    #2;
    chk("R4", "async preset mid-cycle", stage_q, 5'b01111);
    #1;
    clr_n = 1'b0;
    #2;
    chk("R8", "clear with preset active", stage_q, 5'b00110);

    // Held stages ignore clock edges while the serial input toggles.
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      ser_in = ~ser_in;
      chk("R9", $sformatf("hold across edge %0d", k), stage_q, 5'b00110);
    end

    // Release clear first, then preset, one cycle apart.
    clr_n = 1'b1;
    @(posedge clk);
    #1;
    preset_en = 1'b0;
    preset_d  = 5'b11111;
    @(posedge clk);
    #1;
    // Clear alone, mid-cycle, with preset bits set but not enabled.
    #2;
    clr_n = 1'b0;
    #1;
    chk("R7", "async clear mid-cycle", stage_q, 5'b00000);
    chk("R6", "preset bits ignored while disabled", stage_q, 5'b00000);
    @(posedge clk);
    #1;
    chk("R9", "clear holds across edge", stage_q, 5'b00000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule